// File: doc/BRIEF.md
# Width-Converting Synchronous FIFO (32-bit in, 16-bit out)

This block is a single-clock FIFO. Producers write 32-bit words on its wide port and consumers read the same data as 16-bit beats on its narrow port. Each stored word is returned as exactly two beats: the upper half first, then the lower half. The block tracks occupancy in whole entries. An entry stays counted, and its slot stays taken, until both halves have been popped.

The write side is a valid/ready stream. A word transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the FIFO is full or the write side is still coming out of reset. A producer may hold `wr_valid` high with the same data until it sees `wr_ready`.

The read side is a request/response stream. The consumer raises `rd_ready` to request one beat. The request is accepted on an edge where data is held (`rd_empty` low) and the read side is out of reset. The beat then appears on `rd_data`, with `rd_valid` high, for exactly one cycle after that edge. A request made while nothing is held is dropped. The consumer applies back-pressure simply by keeping `rd_ready` low.

Reset is synchronous and active high. After reset, both sides report a short busy window, during which their transfers are refused.

Top module: `wc_fifo_32to16`

## Requirements
- R1: A stored 32-bit word is returned over two accepted reads: first bits 31:16, then bits 15:0.
- R2: `rd_data` and `rd_valid` are registered. `rd_valid` is high exactly in the cycle after an accepted read, and low in every other cycle.
- R3: `rd_empty` is high whenever no half-word is held. It falls in the cycle after the first accepted write into an empty FIFO.
- R4: `wr_count` equals the number of 32-bit entries held. It rises in the cycle after an accepted write, and falls only in the cycle after the second half of an entry is read.
- R5: With DEPTH (default 128) entries held, `wr_full` is high and `wr_ready` is low. A write offered in that state is ignored and leaves the count unchanged.
- R6: A read requested while `rd_empty` is high is ignored. `rd_valid` stays low and the data stream is not disturbed.
- R7: After reset is released, `wr_rst_busy` stays high for 4 cycles and `rd_rst_busy` for 3 cycles. Writes offered while write-busy and reads requested while read-busy are ignored.
- R8: While reset is held, `rd_empty` is 1, `wr_full` is 0, `wr_count` is 0, `rd_valid` is 0, and both busy outputs are 1.
- R9: An accepted write in the same cycle as a read that completes an entry leaves `wr_count` unchanged.
- R10: Words come out in write order, including after the storage pointers wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | 32 | Word offered |
| wr_ready | output | 1 | Word will be taken on this edge |
| wr_full | output | 1 | All entries occupied |
| wr_count | output | 8 | Entries held |
| wr_rst_busy | output | 1 | Write side still leaving reset |
| rd_ready | input | 1 | Consumer requests one beat |
| rd_data | output | 16 | Returned beat |
| rd_valid | output | 1 | `rd_data` holds a beat this cycle |
| rd_empty | output | 1 | No half-word held |
| rd_rst_busy | output | 1 | Read side still leaving reset |

## Verification
Each beat is due one cycle after its read request is accepted. Count, full and empty all settle one cycle after the edge that moves them. The bench drives inputs and samples outputs at the falling edge, so every result is read exactly one cycle after the edge it depends on.

The driver decides whether a transfer will be taken from `wr_ready` and `rd_empty` before that edge. It queues the expected beats in upper-then-lower order, and a monitor compares every `rd_valid` beat against that queue. The busy windows are measured by counting falling edges from the release of reset.

// File: rtl/wc_fifo_pkg.sv
package wc_fifo_pkg;
  localparam int WIDE_W_DEF   = 32;
  localparam int NARROW_W_DEF = 16;
  localparam int DEPTH_DEF    = 128;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wc_fifo_rstseq.sv
module wc_fifo_rstseq #(
  parameter int WR_BUSY_CYC = 4,
  parameter int RD_BUSY_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  output logic wr_busy,
  output logic rd_busy
);
  localparam int MAXC = (WR_BUSY_CYC > RD_BUSY_CYC) ? WR_BUSY_CYC : RD_BUSY_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] age;

  always_ff @(posedge clk) begin
    if (rst)                    age <= '0;
    else if (age != CW'(MAXC))  age <= age + 1'b1;
  end

  assign wr_busy = (age < CW'(WR_BUSY_CYC));
  assign rd_busy = (age < CW'(RD_BUSY_CYC));

  AST_BUSY_ORDER: assert property (@(posedge clk) disable iff (rst)
    !wr_busy |-> !rd_busy); // R7
endmodule

// File: rtl/wc_fifo_store.sv
module wc_fifo_store #(
  parameter int DEPTH  = 128,
  parameter int WIDE_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WIDE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WIDE_W-1:0] rdata
);
  logic [WIDE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/wc_fifo_ctrl.sv
module wc_fifo_ctrl #(
  parameter int DEPTH = 128,
  parameter int RATIO = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = wc_fifo_pkg::idx_width(RATIO),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          wr_busy,
  input  logic          rd_busy,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [BW-1:0] beat,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic last_beat;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign last_beat = (beat == BW'(RATIO - 1));
  assign push      = push_req && !wr_busy && !full;
  assign pop       = pop_req && !rd_busy && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      beat  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop) begin
        if (last_beat) begin
          beat <= '0;
          rptr <= rptr + 1'b1;
        end else begin
          beat <= beat + 1'b1;
        end
      end
      case ({push, pop && last_beat})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_BEAT_MOVES: assert property (@(posedge clk) disable iff (rst)
    pop |=> beat != $past(beat)); // R1
  AST_RPTR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pop && !last_beat) |=> (rptr == $past(rptr)) && (count >= $past(count))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R5
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full); // R5
  AST_SWAP_STEADY: assert property (@(posedge clk) disable iff (rst)
    (push && pop && last_beat) |=> $stable(count)); // R9
endmodule

// File: rtl/wc_fifo_readout.sv
module wc_fifo_readout #(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16,
  localparam int RATIO   = WIDE_W / NARROW_W,
  localparam int BW      = wc_fifo_pkg::idx_width(RATIO)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic [BW-1:0]       beat,
  input  logic [WIDE_W-1:0]   word,
  output logic [NARROW_W-1:0] out_data,
  output logic                out_valid
);
  logic [NARROW_W-1:0] slice [RATIO];

  for (genvar g = 0; g < RATIO; g++) begin : g_slice
    assign slice[g] = word[WIDE_W-1-g*NARROW_W -: NARROW_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= take;
      if (take) out_data <= slice[beat];
    end
  end
endmodule

// File: rtl/wc_fifo_32to16.sv
module wc_fifo_32to16 #(
  parameter int WIDE_W      = wc_fifo_pkg::WIDE_W_DEF,
  parameter int NARROW_W    = wc_fifo_pkg::NARROW_W_DEF,
  parameter int DEPTH       = wc_fifo_pkg::DEPTH_DEF,
  parameter int WR_BUSY_CYC = 4,
  parameter int RD_BUSY_CYC = 3,
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid,
  input  logic [WIDE_W-1:0]   wr_data,
  output logic                wr_ready,
  output logic                wr_full,
  output logic [CW-1:0]       wr_count,
  output logic                wr_rst_busy,
  input  logic                rd_ready,
  output logic [NARROW_W-1:0] rd_data,
  output logic                rd_valid,
  output logic                rd_empty,
  output logic                rd_rst_busy
);
  localparam int RATIO = WIDE_W / NARROW_W;
  localparam int AW    = $clog2(DEPTH);
  localparam int BW    = wc_fifo_pkg::idx_width(RATIO);

  logic              push, pop;
  logic [AW-1:0]     wptr, rptr;
  logic [BW-1:0]     beat;
  logic [WIDE_W-1:0] head;

  wc_fifo_rstseq #(.WR_BUSY_CYC(WR_BUSY_CYC), .RD_BUSY_CYC(RD_BUSY_CYC)) u_rstseq (
    .clk(clk), .rst(rst), .wr_busy(wr_rst_busy), .rd_busy(rd_rst_busy));

  wc_fifo_ctrl #(.DEPTH(DEPTH), .RATIO(RATIO)) u_ctrl (
    .clk(clk), .rst(rst), .push_req(wr_valid), .pop_req(rd_ready),
    .wr_busy(wr_rst_busy), .rd_busy(rd_rst_busy), .push(push), .pop(pop),
    .wptr(wptr), .rptr(rptr), .beat(beat), .count(wr_count),
    .full(wr_full), .empty(rd_empty));

  wc_fifo_store #(.DEPTH(DEPTH), .WIDE_W(WIDE_W)) u_store (
    .clk(clk), .we(push), .waddr(wptr), .wdata(wr_data), .raddr(rptr), .rdata(head));

  wc_fifo_readout #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_readout (
    .clk(clk), .rst(rst), .take(pop), .beat(beat), .word(head),
    .out_data(rd_data), .out_valid(rd_valid));

  assign wr_ready = !wr_full && !wr_rst_busy;

  AST_EMPTY_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && rd_empty) |=> !rd_valid); // R6
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_rst_busy && !pop) |=> $stable(wr_count)); // R7
  AST_FILL_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rd_empty && wr_valid && wr_ready) |=> !rd_empty); // R3
  AST_BEAT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && !rd_empty && !rd_rst_busy) |=> rd_valid); // R2
endmodule

// File: tb/wc_fifo_32to16_test.sv
`timescale 1ns/1ps
module wc_fifo_32to16_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_valid, rd_ready;
  logic [31:0] wr_data;
  logic        wr_ready, wr_full, wr_rst_busy, rd_valid, rd_empty, rd_rst_busy;
  logic [7:0]  wr_count;
  logic [15:0] rd_data;

  int n_vec = 0;
  int n_bad = 0;
  int exp_beats = 0;
  int seen_beats = 0;
  logic [15:0] sb[$];

  always #2 clk = ~clk;

  wc_fifo_32to16 uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_full(wr_full), .wr_count(wr_count),
    .wr_rst_busy(wr_rst_busy), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_empty(rd_empty), .rd_rst_busy(rd_rst_busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: every beat is compared against the scoreboard (R1, R10)
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      seen_beats++;
      if (sb.size() == 0) check(0, "R6 unexpected beat", rd_data, 0);
      else begin
        logic [15:0] e;
        e = sb.pop_front();
        check(rd_data == e, "R1/R10 beat data", rd_data, e);
      end
    end
  end

  task automatic write_word(input logic [31:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    if (wr_ready) begin
      sb.push_back(d[31:16]);
      sb.push_back(d[15:0]);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop_half();
    rd_ready = 1'b1;
    if (!rd_empty && !rd_rst_busy) exp_beats++;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic both(input logic [31:0] d);
    rd_ready = 1'b1;
    if (!rd_empty && !rd_rst_busy) exp_beats++;
    write_word(d);
    rd_ready = 1'b0;
  endtask

  initial begin
    #400000;
    check(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int nw, nr;
    rst = 1'b1; wr_valid = 1'b0; rd_ready = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(rd_empty == 1 && wr_full == 0 && wr_count == 0 && rd_valid == 0,
          "R8 reset state", {rd_empty, wr_full, rd_valid}, 3'b100);
    check(wr_rst_busy && rd_rst_busy, "R8 busy in reset", {wr_rst_busy, rd_rst_busy}, 2'b11);

    rst = 1'b0;
    nw = 0; nr = 0;
    for (int i = 0; i < 12; i++) begin
      if (wr_rst_busy) nw++;
      if (rd_rst_busy) nr++;
      wr_valid = (i == 0);
      rd_ready = (i == 0);
      wr_data  = 32'hDEADBEEF;
      @(negedge clk);
    end
    wr_valid = 1'b0; rd_ready = 1'b0;
    check(nw == 4, "R7 write busy length", nw, 4);
    check(nr == 3, "R7 read busy length", nr, 3);
    check(wr_count == 0 && rd_empty, "R7 write while busy ignored", wr_count, 0);

    pop_half();
    check(rd_valid == 0, "R6 read while empty", rd_valid, 0);

    write_word(32'hA1B2C3D4);
    check(rd_empty == 0, "R3 empty falls after write", rd_empty, 0);
    check(wr_count == 1, "R4 count after write", wr_count, 1);
    pop_half();
    check(rd_valid && rd_data == 16'hA1B2, "R1 upper half first", rd_data, 16'hA1B2);
    check(wr_count == 1, "R4 count held after first half", wr_count, 1);
    pop_half();
    check(rd_valid && rd_data == 16'hC3D4, "R1 lower half second", rd_data, 16'hC3D4);
    check(wr_count == 0 && rd_empty, "R3 empty after both halves", wr_count, 0);
    @(negedge clk);
    check(rd_valid == 0, "R2 no beat without read", rd_valid, 0);

    for (int i = 0; i < 128; i++) write_word(32'h1000_0000 + i * 32'h0001_0003);
    check(wr_full && !wr_ready, "R5 full at depth", {wr_full, wr_ready}, 2'b10);
    check(wr_count == 128, "R5 count at depth", wr_count, 128);
    write_word(32'hFFFF_0000);
    check(wr_count == 128, "R5 write while full ignored", wr_count, 128);

    pop_half();
    check(wr_count == 128 && wr_full, "R4 full held after first half", wr_count, 128);
    pop_half();
    check(wr_count == 127 && !wr_full, "R4 count drops after second half", wr_count, 127);
    pop_half();
    both(32'h5566_7788);
    check(wr_count == 127, "R9 write with completing read", wr_count, 127);

    for (int k = 0; k < 400 && !rd_empty; k++) pop_half();
    @(negedge clk);
    check(rd_empty && wr_count == 0, "R10 drained after wrap", wr_count, 0);
    check(sb.size() == 0, "R10 all beats returned", sb.size(), 0);
    check(seen_beats == exp_beats, "R2 one beat per accepted read", seen_beats, exp_beats);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule